// File: doc/BRIEF.md
# Width-converting three-port burst crossbar slice

This block is one data slice of a three-port crossbar. It joins a wide memory port (four units per beat), a processor port (two units per beat) and a narrow I/O port (one unit per beat). Every transfer moves one burst of eight units, D0 to D7. The source port delivers the burst in its own number of beats, and the destination port sends it out in its own number of beats. A burst is two beats on the memory port, four on the processor port and eight on the I/O port. Single processor/I/O transfers move only the first processor beat, which is units D0 and D1.

A 4-bit command starts each transfer. The slice first gathers the source beats into a burst buffer and then sends the destination beats from registered outputs. Each port has its own output enable, which stands in for the tristate pad control. Unloading a memory read onto the processor or I/O port moves forward only on clocks where the read-buffer strobe is high. Unloading a memory write onto the memory port moves forward only on clocks where the write-buffer strobe is high. This lets the memory side wait for its own timing. A test command echoes processor data, with its units duplicated, onto the memory and I/O ports. A reset command stops all driving at any time.

Top module: `xbar_slice`

## Requirements
- R1: While rst_n is low, and until the first command is accepted after reset, busy is 0 and mem_oe, prc_oe and io_oe are 0.
- R2: Command codes are 4'h1 memory to I/O, 4'h2 memory to processor, 4'h3 processor to memory, 4'h4 I/O to memory, 4'h5 processor to I/O single, 4'h6 processor to I/O block, 4'h7 I/O to processor single, 4'h8 I/O to processor block, 4'h9 test and 4'hF reset. A command from 1 to 9 is accepted on a clock edge where busy is 0, and busy is 1 from the next cycle on. Codes 4'h0 and 4'hA to 4'hE have no effect: busy and all enables stay 0.
- R3: A memory beat holds four units. Beat b carries units D(4b) to D(4b+3), and unit D(4b+j) sits at mem bits [4j+3:4j] (for a unit width of 4).
- R4: A processor beat holds two units. Beat b carries D(2b) in bits [3:0] and D(2b+1) in bits [7:4].
- R5: I/O beat b carries unit Db, so units go out and come in in ascending order.
- R6: In a memory read (codes 1, 2), the two memory beats are captured on the two clock edges after acceptance. Each destination beat is then loaded on the next edge where rd_strobe is 1, and it shows on the port from that edge on. Edges where rd_strobe is 0 leave the outputs and enables unchanged.
- R7: In a memory write (codes 3, 4), the source beats are captured on the consecutive edges after acceptance. Each memory beat is then loaded on the next edge where wr_strobe is 1, and edges where wr_strobe is 0 leave the memory outputs unchanged.
- R8: Processor/I/O transfers ignore both strobes. The block forms (6, 8) move all eight units. The single forms (5, 7) move only D0 and D1: processor to I/O gives two I/O beats, and I/O to processor gives one processor beat.
- R9: In test mode (code 9), each of the four processor beats p sampled on the edges after acceptance shows from that edge on as mem_o = {p,p} and io_o = p[3:0]. During this, mem_oe and io_oe are 1 and prc_oe is 0.
- R10: Code 4'hF, on any edge, busy or not, sets busy and all enables to 0 from the next cycle.
- R11: During a transfer only the destination port's enable is ever 1. One cycle after the last destination beat first shows, all enables and busy return to 0.
- R12: Any command other than 4'hF that arrives while busy is 1 is ignored, and the running transfer finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 4 | Transfer command, sampled each clock |
| rd_strobe | input | 1 | Memory read-buffer unload enable |
| wr_strobe | input | 1 | Memory write-buffer unload enable |
| mem_i | input | 16 | Memory port input data |
| mem_o | output | 16 | Memory port output data |
| mem_oe | output | 1 | Memory port drive enable |
| prc_i | input | 8 | Processor port input data |
| prc_o | output | 8 | Processor port output data |
| prc_oe | output | 1 | Processor port drive enable |
| io_i | input | 4 | I/O port input data |
| io_o | output | 4 | I/O port output data |
| io_oe | output | 1 | I/O port drive enable |
| busy | output | 1 | A transfer is in progress |

## Verification
If a command is accepted on edge E0, source beat k is captured on edge E(k+1). Each destination beat appears one edge after its unload edge, and that unload edge is the next edge with the strobe high for gated transfers, or the next edge for ungated ones. The enables and busy fall on the edge after that. The bench drives on the falling edge and samples on the falling edge half a period after each rising edge. It follows this count for every beat. It also inserts stall cycles with the strobe low, where it expects the previous beat (or no drive) to hold. Test echoes, reset aborts and ignored codes are checked in the cycle right after the edge that takes them.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam logic [3:0] CMD_IDLE  = 4'h0;
  localparam logic [3:0] CMD_MI    = 4'h1;
  localparam logic [3:0] CMD_MP    = 4'h2;
  localparam logic [3:0] CMD_PM    = 4'h3;
  localparam logic [3:0] CMD_IM    = 4'h4;
  localparam logic [3:0] CMD_PIS   = 4'h5;
  localparam logic [3:0] CMD_PIB   = 4'h6;
  localparam logic [3:0] CMD_IPS   = 4'h7;
  localparam logic [3:0] CMD_IPB   = 4'h8;
  localparam logic [3:0] CMD_TEST  = 4'h9;
  localparam logic [3:0] CMD_RESET = 4'hF;

  localparam int BURST_UNITS = 8;
  localparam int MEM_UNITS   = 4;
  localparam int PRC_UNITS   = 2;
  localparam int MEM_BEATS   = BURST_UNITS / MEM_UNITS;
  localparam int PRC_BEATS   = BURST_UNITS / PRC_UNITS;
  localparam int IO_BEATS    = BURST_UNITS;
  localparam int CNT_W       = $clog2(BURST_UNITS + 1);

  typedef enum logic [1:0] {PORT_NONE, PORT_MEM, PORT_PRC, PORT_IO} port_e;
  typedef enum logic [2:0] {PH_IDLE, PH_LOAD, PH_UNLOAD, PH_TEST, PH_DRAIN} phase_e;

  typedef struct packed {
    port_e            src;
    port_e            dst;
    logic [CNT_W-1:0] n_load;
    logic [CNT_W-1:0] n_unload;
    logic             gate_rd;
    logic             gate_wr;
  } route_t;

  typedef struct packed {
    logic   start;
    logic   test;
    logic   abort;
    route_t r;
  } xfer_t;

  function automatic logic [2:0] port_mask(port_e p);
    unique case (p)
      PORT_MEM: return 3'b100;
      PORT_PRC: return 3'b010;
      PORT_IO:  return 3'b001;
      default:  return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/xbar_cmd_decode.sv
module xbar_cmd_decode
  import xbar_pkg::*;
(
  input  logic [3:0] cmd,
  output xfer_t      xfer
);
  function automatic route_t mk(port_e s, port_e d, int nl, int nu, logic rd, logic wr);
    route_t r;
    r.src      = s;
    r.dst      = d;
    r.n_load   = CNT_W'(nl);
    r.n_unload = CNT_W'(nu);
    r.gate_rd  = rd;
    r.gate_wr  = wr;
    return r;
  endfunction

  always_comb begin
    xfer       = '0;
    xfer.start = 1'b1;
    unique case (cmd)
      CMD_MI:    xfer.r = mk(PORT_MEM, PORT_IO,  MEM_BEATS, IO_BEATS,  1'b1, 1'b0);
      CMD_MP:    xfer.r = mk(PORT_MEM, PORT_PRC, MEM_BEATS, PRC_BEATS, 1'b1, 1'b0);
      CMD_PM:    xfer.r = mk(PORT_PRC, PORT_MEM, PRC_BEATS, MEM_BEATS, 1'b0, 1'b1);
      CMD_IM:    xfer.r = mk(PORT_IO,  PORT_MEM, IO_BEATS,  MEM_BEATS, 1'b0, 1'b1);
      CMD_PIS:   xfer.r = mk(PORT_PRC, PORT_IO,  1, PRC_UNITS, 1'b0, 1'b0);
      CMD_PIB:   xfer.r = mk(PORT_PRC, PORT_IO,  PRC_BEATS, IO_BEATS,  1'b0, 1'b0);
      CMD_IPS:   xfer.r = mk(PORT_IO,  PORT_PRC, PRC_UNITS, 1, 1'b0, 1'b0);
      CMD_IPB:   xfer.r = mk(PORT_IO,  PORT_PRC, IO_BEATS,  PRC_BEATS, 1'b0, 1'b0);
      CMD_TEST: begin
        xfer.test = 1'b1;
        xfer.r    = mk(PORT_NONE, PORT_NONE, PRC_BEATS, 0, 1'b0, 1'b0);
      end
      CMD_RESET: begin
        xfer.start = 1'b0;
        xfer.abort = 1'b1;
      end
      default:   xfer.start = 1'b0;
    endcase
  end
endmodule

// File: rtl/xbar_seq.sv
module xbar_seq
  import xbar_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  xfer_t            dec,
  input  logic             rd_strobe,
  input  logic             wr_strobe,
  output phase_e           ph,
  output route_t           route,
  output logic [CNT_W-1:0] cnt,
  output logic             load_en,
  output logic             unload_en,
  output logic             test_en,
  output logic [2:0]       oe,
  output logic             busy
);
  phase_e           ph_n;
  route_t           route_n;
  logic [CNT_W-1:0] cnt_n;
  logic [2:0]       oe_n;
  logic             gate_ok;

  assign gate_ok = (!route.gate_rd || rd_strobe) && (!route.gate_wr || wr_strobe);
  assign busy    = (ph != PH_IDLE);

  always_comb begin
    ph_n      = ph;
    route_n   = route;
    cnt_n     = cnt;
    oe_n      = oe;
    load_en   = 1'b0;
    unload_en = 1'b0;
    test_en   = 1'b0;
    if (dec.abort) begin
      ph_n  = PH_IDLE;
      cnt_n = '0;
      oe_n  = '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (dec.start) begin
          route_n = dec.r;
          cnt_n   = '0;
          ph_n    = dec.test ? PH_TEST : PH_LOAD;
        end
        PH_LOAD: begin
          load_en = 1'b1;
          cnt_n   = cnt + 1'b1;
          if (cnt == route.n_load - 1'b1) begin
            cnt_n = '0;
            ph_n  = PH_UNLOAD;
          end
        end
        PH_UNLOAD: if (gate_ok) begin
          unload_en = 1'b1;
          oe_n      = port_mask(route.dst);
          cnt_n     = cnt + 1'b1;
          if (cnt == route.n_unload - 1'b1) ph_n = PH_DRAIN;
        end
        PH_TEST: begin
          test_en = 1'b1;
          oe_n    = port_mask(PORT_MEM) | port_mask(PORT_IO);
          cnt_n   = cnt + 1'b1;
          if (cnt == route.n_load - 1'b1) ph_n = PH_DRAIN;
        end
        PH_DRAIN: begin
          oe_n = '0;
          ph_n = PH_IDLE;
        end
        default: ph_n = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      route <= '0;
      cnt   <= '0;
      oe    <= '0;
    end else begin
      ph    <= ph_n;
      route <= route_n;
      cnt   <= cnt_n;
      oe    <= oe_n;
    end
  end
endmodule

// File: rtl/xbar_burst_buf.sv
module xbar_burst_buf
  import xbar_pkg::*;
#(
  parameter int UNIT_W = 4,
  localparam int MEM_W   = MEM_UNITS * UNIT_W,
  localparam int PRC_W   = PRC_UNITS * UNIT_W,
  localparam int BURST_W = BURST_UNITS * UNIT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             unload_en,
  input  logic             test_en,
  input  port_e            src,
  input  port_e            dst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [MEM_W-1:0] mem_i,
  input  logic [PRC_W-1:0] prc_i,
  input  logic [UNIT_W-1:0] io_i,
  output logic [MEM_W-1:0] mem_o,
  output logic [PRC_W-1:0] prc_o,
  output logic [UNIT_W-1:0] io_o
);
  logic [BURST_W-1:0] burst;
  logic [MEM_W-1:0]   mem_n;
  logic [PRC_W-1:0]   prc_n;
  logic [UNIT_W-1:0]  io_n;

  for (genvar u = 0; u < BURST_UNITS; u++) begin : g_unit
    logic [UNIT_W-1:0] q, d;
    logic              we;
    always_comb begin
      we = 1'b0;
      d  = q;
      if (load_en) begin
        unique case (src)
          PORT_MEM: begin
            we = (cnt == CNT_W'(u / MEM_UNITS));
            d  = mem_i[(u % MEM_UNITS)*UNIT_W +: UNIT_W];
          end
          PORT_PRC: begin
            we = (cnt == CNT_W'(u / PRC_UNITS));
            d  = prc_i[(u % PRC_UNITS)*UNIT_W +: UNIT_W];
          end
          PORT_IO: begin
            we = (cnt == CNT_W'(u));
            d  = io_i;
          end
          default: we = 1'b0;
        endcase
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
    end
    assign burst[u*UNIT_W +: UNIT_W] = q;
  end

  always_comb begin
    mem_n = mem_o;
    prc_n = prc_o;
    io_n  = io_o;
    if (test_en) begin
      mem_n = {(MEM_UNITS / PRC_UNITS){prc_i}};
      io_n  = prc_i[UNIT_W-1:0];
    end else if (unload_en) begin
      unique case (dst)
        PORT_MEM: mem_n = MEM_W'(burst >> (int'(cnt) * MEM_W));
        PORT_PRC: prc_n = PRC_W'(burst >> (int'(cnt) * PRC_W));
        PORT_IO:  io_n  = UNIT_W'(burst >> (int'(cnt) * UNIT_W));
        default:  mem_n = mem_o;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_o <= '0;
      prc_o <= '0;
      io_o  <= '0;
    end else begin
      mem_o <= mem_n;
      prc_o <= prc_n;
      io_o  <= io_n;
    end
  end
endmodule

// File: rtl/xbar_slice.sv
module xbar_slice
  import xbar_pkg::*;
#(
  parameter int UNIT_W = 4,
  localparam int MEM_W = MEM_UNITS * UNIT_W,
  localparam int PRC_W = PRC_UNITS * UNIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cmd,
  input  logic              rd_strobe,
  input  logic              wr_strobe,
  input  logic [MEM_W-1:0]  mem_i,
  output logic [MEM_W-1:0]  mem_o,
  output logic              mem_oe,
  input  logic [PRC_W-1:0]  prc_i,
  output logic [PRC_W-1:0]  prc_o,
  output logic              prc_oe,
  input  logic [UNIT_W-1:0] io_i,
  output logic [UNIT_W-1:0] io_o,
  output logic              io_oe,
  output logic              busy
);
  logic [1:0]       rst_sync;
  logic             rst_q;
  xfer_t            dec;
  phase_e           ph;
  route_t           route;
  logic [CNT_W-1:0] cnt;
  logic             load_en, unload_en, test_en;
  logic [2:0]       oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  xbar_cmd_decode u_dec (.cmd(cmd), .xfer(dec));

  xbar_seq u_seq (
    .clk(clk), .rst_n(rst_q), .dec(dec), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .ph(ph), .route(route), .cnt(cnt), .load_en(load_en), .unload_en(unload_en),
    .test_en(test_en), .oe(oe), .busy(busy)
  );

  xbar_burst_buf #(.UNIT_W(UNIT_W)) u_buf (
    .clk(clk), .rst_n(rst_q), .load_en(load_en), .unload_en(unload_en), .test_en(test_en),
    .src(route.src), .dst(route.dst), .cnt(cnt), .mem_i(mem_i), .prc_i(prc_i), .io_i(io_i),
    .mem_o(mem_o), .prc_o(prc_o), .io_o(io_o)
  );

  assign {mem_oe, prc_oe, io_oe} = oe;
endmodule

// File: rtl/xbar_slice_chk.sv
module xbar_slice_chk
  import xbar_pkg::*;
#(
  parameter int UNIT_W = 4,
  localparam int MEM_W = MEM_UNITS * UNIT_W,
  localparam int PRC_W = PRC_UNITS * UNIT_W
) (
  input logic              clk,
  input logic              rst_q,
  input logic [3:0]        cmd,
  input logic              rd_strobe,
  input logic              wr_strobe,
  input logic              busy,
  input logic              mem_oe,
  input logic              prc_oe,
  input logic              io_oe,
  input logic [MEM_W-1:0]  mem_o,
  input logic [PRC_W-1:0]  prc_o,
  input logic [UNIT_W-1:0] io_o,
  input phase_e            ph,
  input logic              gate_rd,
  input logic              gate_wr
);
  // R10
  a_r10_reset_cmd: assert property (@(posedge clk) disable iff (!rst_q)
    cmd == CMD_RESET |=> !busy && !mem_oe && !prc_oe && !io_oe);

  // R1, R11
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_q)
    !busy |-> !mem_oe && !prc_oe && !io_oe);

  // R2
  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_q)
    (!busy && cmd >= CMD_MI && cmd <= CMD_TEST) |=> busy);

  // R6
  a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_q)
    (ph == PH_UNLOAD && gate_rd && !rd_strobe && cmd != CMD_RESET)
      |=> $stable({prc_o, io_o, prc_oe, io_oe}));

  // R7
  a_r7_wr_hold: assert property (@(posedge clk) disable iff (!rst_q)
    (ph == PH_UNLOAD && gate_wr && !wr_strobe && cmd != CMD_RESET)
      |=> $stable({mem_o, mem_oe}));

  // R11, R9
  a_r11_one_driver: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({mem_oe, prc_oe, io_oe}) || (mem_oe && io_oe && !prc_oe));
endmodule

bind xbar_slice xbar_slice_chk #(.UNIT_W(UNIT_W)) u_chk (
  .clk(clk), .rst_q(rst_q), .cmd(cmd), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
  .busy(busy), .mem_oe(mem_oe), .prc_oe(prc_oe), .io_oe(io_oe),
  .mem_o(mem_o), .prc_o(prc_o), .io_o(io_o), .ph(ph),
  .gate_rd(route.gate_rd), .gate_wr(route.gate_wr)
);

// File: tb/test_xbar_slice.sv
module test_xbar_slice;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cmd;
  logic        rd_strobe, wr_strobe;
  logic [15:0] mem_i, mem_o;
  logic [7:0]  prc_i, prc_o;
  logic [3:0]  io_i, io_o;
  logic        mem_oe, prc_oe, io_oe, busy;
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 0;

  always #10 clk = ~clk;

  xbar_slice i_xbar_slice (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .mem_i(mem_i), .mem_o(mem_o), .mem_oe(mem_oe), .prc_i(prc_i), .prc_o(prc_o),
    .prc_oe(prc_oe), .io_i(io_i), .io_o(io_o), .io_oe(io_oe), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  function automatic logic [31:0] beat(input logic [31:0] bd, input int w, input int k);
    logic [31:0] m;
    m = (32'h1 << w) - 1;
    return (bd >> (w * k)) & m;
  endfunction

  // port codes: 1 memory, 2 processor, 3 I/O
  task automatic run_xfer(input logic [3:0] c, input logic [31:0] bd, input bit stall,
                          input logic [3:0] intruder, input string tag);
    int src, dst, nl, nu, dw;
    bit gated;
    logic [2:0] mask;
    logic [31:0] act;
    case (c)
      4'h1: begin src = 1; dst = 3; nl = 2; nu = 8; end
      4'h2: begin src = 1; dst = 2; nl = 2; nu = 4; end
      4'h3: begin src = 2; dst = 1; nl = 4; nu = 2; end
      4'h4: begin src = 3; dst = 1; nl = 8; nu = 2; end
      4'h5: begin src = 2; dst = 3; nl = 1; nu = 2; end
      4'h6: begin src = 2; dst = 3; nl = 4; nu = 8; end
      4'h7: begin src = 3; dst = 2; nl = 2; nu = 1; end
      default: begin src = 3; dst = 2; nl = 8; nu = 4; end
    endcase
    gated = (c <= 4'h4);
    dw    = (dst == 1) ? 16 : (dst == 2) ? 8 : 4;
    mask  = (dst == 1) ? 3'b100 : (dst == 2) ? 3'b010 : 3'b001;
    @(negedge clk) cmd = c;
    @(negedge clk) cmd = 4'h0;
    chk({tag, " R2 busy after accept"}, {31'b0, busy}, 1);
    for (int k = 0; k < nl; k++) begin
      mem_i = (src == 1) ? beat(bd, 16, k) : 16'hA5C3 ^ 16'(k);
      prc_i = (src == 2) ? beat(bd, 8, k)  : 8'h3C ^ 8'(k);
      io_i  = (src == 3) ? beat(bd, 4, k)  : 4'h9 ^ 4'(k);
      if (k == 0 && intruder != 4'h0) cmd = intruder;
      @(negedge clk);
    end
    cmd = 4'h0;
    for (int j = 0; j < nu; j++) begin
      if (stall && gated) begin
        rd_strobe = 1'b0; wr_strobe = 1'b0;
        @(negedge clk);
        chk({tag, " R6 R7 stall holds enables"}, {29'b0, mem_oe, prc_oe, io_oe},
            (j == 0) ? 32'h0 : {29'b0, mask});
        act = (dst == 1) ? {16'b0, mem_o} : (dst == 2) ? {24'b0, prc_o} : {28'b0, io_o};
        if (j > 0) chk({tag, " R6 R7 stall holds data"}, act, beat(bd, dw, j - 1));
      end
      rd_strobe = 1'b1; wr_strobe = 1'b1;
      @(negedge clk);
      act = (dst == 1) ? {16'b0, mem_o} : (dst == 2) ? {24'b0, prc_o} : {28'b0, io_o};
      chk({tag, (dst == 1) ? " R3" : (dst == 2) ? " R4" : " R5", " R8 beat data"},
          act, beat(bd, dw, j));
      chk({tag, " R11 only destination drives"}, {29'b0, mem_oe, prc_oe, io_oe}, {29'b0, mask});
    end
    rd_strobe = 1'b0; wr_strobe = 1'b0;
    @(negedge clk);
    chk({tag, " R11 enables off after burst"}, {29'b0, mem_oe, prc_oe, io_oe}, 0);
    chk({tag, " R11 R12 busy low after burst"}, {31'b0, busy}, 0);
  endtask

  task automatic run_test(input logic [31:0] bd);
    logic [7:0] p;
    @(negedge clk) cmd = 4'h9;
    @(negedge clk) cmd = 4'h0;
    for (int k = 0; k < 4; k++) begin
      p = beat(bd, 8, k);
      prc_i = p; mem_i = 16'h1234; io_i = 4'h6;
      @(negedge clk);
      chk("R9 test memory echo", {16'b0, mem_o}, {16'b0, p, p});
      chk("R9 test io echo", {28'b0, io_o}, {28'b0, p[3:0]});
      chk("R9 test enables", {29'b0, mem_oe, prc_oe, io_oe}, 32'h5);
    end
    @(negedge clk);
    chk("R9 R11 test end quiet", {28'b0, busy, mem_oe, prc_oe, io_oe}, 0);
  endtask

  initial begin
    logic [31:0] bd;
    rst_n = 1'b0; cmd = 4'h0; rd_strobe = 1'b0; wr_strobe = 1'b0;
    mem_i = '0; prc_i = '0; io_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset state", {28'b0, busy, mem_oe, prc_oe, io_oe}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {28'b0, busy, mem_oe, prc_oe, io_oe}, 0);

    for (int p = 0; p < 4; p++) begin
      bd = 32'h7654_3210 ^ (32'(p) * 32'h9E37_79B9);
      for (int c = 1; c <= 8; c++)
        run_xfer(4'(c), bd, p[0], 4'h0, $sformatf("cmd%0d pat%0d", c, p));
    end

    run_xfer(4'h6, 32'hFEDC_BA98, 1'b0, 4'h1, "R12 intruder MI during PIB");
    run_xfer(4'h3, 32'h0F1E_2D3C, 1'b1, 4'h9, "R12 intruder TEST during PM");

    run_test(32'h89AB_CDEF);
    run_test(32'h1357_9BDF);

    // R10: abort while memory read unload is driving
    @(negedge clk) cmd = 4'h1;
    @(negedge clk) cmd = 4'h0;
    mem_i = 16'hBEEF; @(negedge clk);
    mem_i = 16'hCAFE; @(negedge clk);
    rd_strobe = 1'b1; @(negedge clk);
    chk("R10 io driving before abort", {31'b0, io_oe}, 1);
    cmd = 4'hF;
    @(negedge clk);
    cmd = 4'h0; rd_strobe = 1'b0;
    chk("R10 abort clears", {28'b0, busy, mem_oe, prc_oe, io_oe}, 0);
    @(negedge clk);
    chk("R10 stays idle", {28'b0, busy, mem_oe, prc_oe, io_oe}, 0);

    // R10: abort during load
    @(negedge clk) cmd = 4'h4;
    @(negedge clk) cmd = 4'hF;
    @(negedge clk) cmd = 4'h0;
    chk("R10 abort during load", {28'b0, busy, mem_oe, prc_oe, io_oe}, 0);

    // R2: codes with no effect
    for (int c = 10; c <= 14; c++) begin
      @(negedge clk) cmd = 4'(c);
      @(negedge clk) cmd = 4'h0;
      chk($sformatf("R2 code %0h ignored", c), {28'b0, busy, mem_oe, prc_oe, io_oe}, 0);
    end
    @(negedge clk) cmd = 4'h0;
    @(negedge clk);
    chk("R2 idle code", {28'b0, busy, mem_oe, prc_oe, io_oe}, 0);

    summary();
  end
endmodule